// File: doc/BRIEF.md
# Page Word Buffer

This block gathers the data words of a multi-word program instruction for a serial non-volatile memory and hands them to the array as one batch. At the start of each instruction it takes a start address. The upper address bits name a four-word page and stay fixed for the whole instruction. The two lower bits are the starting slot inside that page. Each complete word from the serial shifter goes into the current slot, and the slot pointer then moves on by one. The pointer wraps inside the page, so a host that sends more than four words overwrites the earlier slots and never spills into the next page.

When the chip select falls after the last data bit, the surrounding control logic raises a commit request. The block then walks the four slots in ascending address order, one slot per clock, and presents an address/data pair for every slot that was loaded during the current instruction. It pulses a done flag one cycle after the last slot. Slots that were not loaded produce no write, so those words keep their old contents in the array.

If chip select falls in the middle of a word, the control logic reports the cut word. The block then discards the whole instruction: a later commit request produces no writes and no done pulse. The storage array and the serial shift register are outside this block.

Top module: `page_word_buffer`

## Requirements
- R1: A `clr` pulse loads the page base (address bits above the low two) and the slot pointer (the low two bits) from `start_addr`, clears every loaded flag and clears the discard state. If `clr` and `word_vld` are high in the same cycle, the word is dropped.
- R2: Each accepted `word_vld` stores `word_data` in the slot named by the pointer and marks that slot loaded. Then, and only then, the pointer advances by one. The page base does not change between `clr` pulses, so every committed `wr_addr` carries the base from the last `clr` in bits above bit 1.
- R3: The pointer wraps from slot 3 to slot 0. When more words are sent than there are slots, each new word replaces the older one in its slot. For example, with six words sent from slot 0, slot 0 ends up holding word 5 and slot 1 holds word 6.
- R4: A `commit_req` seen while idle and not discarding starts a scan in the following cycle. The scan lasts four cycles and covers slots 0, 1, 2 and 3 in that order. In each scan cycle `wr_addr` equals {base, slot}. `wr_vld` is 1 with the most recent word of that slot in `wr_data` if the slot is loaded, and 0 if it is not.
- R5: `commit_done` is high for exactly one cycle, the cycle after the slot-3 scan cycle, and `wr_vld` is 0 in that cycle. `busy` is 1 from the first scan cycle through the done cycle. A commit with no loaded slots still scans and pulses done.
- R6: A `partial_abort` pulse while idle puts the instruction in discard state. From then until the next `clr`, `commit_req` is ignored: `busy`, `wr_vld` and `commit_done` stay 0.
- R7: While `busy` is 1, `clr`, `word_vld` and `commit_req` are ignored. A second commit issued without a new `clr` therefore writes the same pairs again.
- R8: After reset the block is idle with no slot loaded, and `wr_vld`, `commit_done` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Instruction start; loads `start_addr` and clears slots |
| start_addr | input | 8 | Start address of the instruction |
| word_vld | input | 1 | One complete word is on `word_data` |
| word_data | input | 16 | Word from the serial shifter |
| partial_abort | input | 1 | Chip select fell inside a word; discard the instruction |
| commit_req | input | 1 | Start writing the collected words |
| wr_vld | output | 1 | `wr_addr`/`wr_data` hold a pair to program |
| wr_addr | output | 8 | Array address of the current pair |
| wr_data | output | 16 | Data of the current pair |
| commit_done | output | 1 | One-cycle pulse after the last slot |
| busy | output | 1 | Commit scan in progress |

## Verification
Some properties are checked by assertions on every cycle:
- a scan always opens at slot 0;
- done comes only right after the slot-3 scan cycle, and never together with a write;
- no scan starts from discard state;
- a `clr` leaves every slot empty;
- the page base holds still between `clr` pulses;
- words that arrive during a scan leave the loaded flags unchanged.

Other behaviour depends on data and on the order of stimulus, so only the bench scenarios show it: which word survives in each slot after the pointer wraps, that slots not sent produce no write, that `clr` wins over a word in the same cycle, and that a repeated commit writes the same pairs.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    parameter int unsigned ADDR_W     = 8;
    parameter int unsigned DATA_W     = 16;
    parameter int unsigned PAGE_WORDS = 4;

    localparam int unsigned OFS_W  = $clog2(PAGE_WORDS);
    localparam int unsigned BASE_W = ADDR_W - OFS_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam ofs_t LAST_OFS = ofs_t'(PAGE_WORDS - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } cstate_e;

    typedef struct packed {
        logic  vld;
        addr_t addr;
        word_t data;
    } wr_pair_t;

    function automatic ofs_t ofs_next(ofs_t o);
        return ofs_t'(o + 1'b1);
    endfunction

    function automatic addr_t join_addr(base_t b, ofs_t o);
        return {b, o};
    endfunction

    function automatic base_t addr_base(addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic ofs_t addr_ofs(addr_t a);
        return a[OFS_W-1:0];
    endfunction

endpackage

// File: rtl/pwb_ptr.sv
module pwb_ptr
    import pwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t start_addr,
    input  logic  step,
    output base_t base,
    output ofs_t  ofs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            ofs  <= '0;
        end else if (load) begin
            base <= addr_base(start_addr);
            ofs  <= addr_ofs(start_addr);
        end else if (step) begin
            ofs  <= ofs_next(ofs);
        end
    end

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(base)); // R2

endmodule

// File: rtl/pwb_store.sv
module pwb_store
    import pwb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr_en,
    input  ofs_t                  wr_ofs,
    input  word_t                 wr_data,
    input  ofs_t                  rd_ofs,
    output logic                  rd_loaded,
    output word_t                 rd_data,
    output logic [PAGE_WORDS-1:0] loaded_vec
);

    logic [PAGE_WORDS-1:0] loaded;
    word_t                 slot_q [PAGE_WORDS];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            loaded <= '0;
        end else begin
            for (int i = 0; i < PAGE_WORDS; i++) begin
                if (wr_en && (wr_ofs == ofs_t'(i))) begin
                    loaded[i] <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ofs == ofs_t'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_loaded  = loaded[rd_ofs];
    assign rd_data    = slot_q[rd_ofs];
    assign loaded_vec = loaded;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (loaded_vec == '0)); // R1

endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
    import pwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic partial_abort,
    input  logic commit_req,
    output logic busy,
    output logic scanning,
    output ofs_t scan_ofs,
    output logic commit_done
);

    cstate_e state;
    logic    discard;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            scan_ofs <= '0;
            discard  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (clr) begin
                        discard <= 1'b0;
                    end else if (partial_abort) begin
                        discard <= 1'b1;
                    end else if (commit_req && !discard) begin
                        state    <= ST_SCAN;
                        scan_ofs <= '0;
                    end
                end
                ST_SCAN: begin
                    scan_ofs <= ofs_next(scan_ofs);
                    if (scan_ofs == LAST_OFS) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign scanning    = (state == ST_SCAN);
    assign commit_done = (state == ST_DONE);

    AST_SCAN_OPENS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(scanning) |-> (scan_ofs == '0)); // R4

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        commit_done |-> $past(scanning && (scan_ofs == LAST_OFS))); // R5

    AST_NO_COMMIT_DISCARDED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(discard)); // R6

endmodule

// File: rtl/page_word_buffer.sv
module page_word_buffer
    import pwb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic [7:0]  start_addr,
    input  logic        word_vld,
    input  logic [15:0] word_data,
    input  logic        partial_abort,
    input  logic        commit_req,
    output logic        wr_vld,
    output logic [7:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        commit_done,
    output logic        busy
);

    logic                  acc_clr;
    logic                  acc_word;
    base_t                 base;
    ofs_t                  wr_ofs;
    logic                  scanning;
    ofs_t                  scan_ofs;
    logic                  rd_loaded;
    word_t                 rd_data;
    logic [PAGE_WORDS-1:0] loaded_vec;
    wr_pair_t              pair;

    assign acc_clr  = clr && !busy;
    assign acc_word = word_vld && !clr && !busy;

    pwb_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .load       (acc_clr),
        .start_addr (start_addr),
        .step       (acc_word),
        .base       (base),
        .ofs        (wr_ofs)
    );

    pwb_store u_store (
        .clk        (clk),
        .rst        (rst),
        .clr        (acc_clr),
        .wr_en      (acc_word),
        .wr_ofs     (wr_ofs),
        .wr_data    (word_data),
        .rd_ofs     (scan_ofs),
        .rd_loaded  (rd_loaded),
        .rd_data    (rd_data),
        .loaded_vec (loaded_vec)
    );

    pwb_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .clr           (clr),
        .partial_abort (partial_abort),
        .commit_req    (commit_req),
        .busy          (busy),
        .scanning      (scanning),
        .scan_ofs      (scan_ofs),
        .commit_done   (commit_done)
    );

    always_comb begin
        pair.vld  = scanning && rd_loaded;
        pair.addr = join_addr(base, scan_ofs);
        pair.data = rd_data;
    end

    assign wr_vld  = pair.vld;
    assign wr_addr = pair.addr;
    assign wr_data = pair.data;

    AST_DONE_NOT_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_vld, commit_done})); // R5

    AST_BUSY_IGNORES_WORDS: assert property (@(posedge clk) disable iff (rst)
        (busy && word_vld) |=> $stable(loaded_vec)); // R7

endmodule

// File: tb/tb_page_word_buffer.sv
module tb_page_word_buffer;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr = 1'b0;
    logic [7:0]  start_addr = '0;
    logic        word_vld = 1'b0;
    logic [15:0] word_data = '0;
    logic        partial_abort = 1'b0;
    logic        commit_req = 1'b0;
    logic        wr_vld;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;
    logic        commit_done;
    logic        busy;

    int n_tests = 0;
    int n_fail  = 0;

    logic        m_loaded [4];
    logic [15:0] m_data   [4];
    logic [5:0]  m_base;
    logic [1:0]  m_ofs;

    always #10 clk = ~clk;

    page_word_buffer dut (
        .clk(clk), .rst(rst), .clr(clr), .start_addr(start_addr),
        .word_vld(word_vld), .word_data(word_data),
        .partial_abort(partial_abort), .commit_req(commit_req),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_done(commit_done), .busy(busy)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_instr(logic [7:0] a);
        clr = 1'b1; start_addr = a;
        @(negedge clk);
        clr = 1'b0;
        m_base = a[7:2]; m_ofs = a[1:0];
        for (int i = 0; i < 4; i++) m_loaded[i] = 1'b0;
    endtask

    task automatic send_word(logic [15:0] d);
        word_vld = 1'b1; word_data = d;
        @(negedge clk);
        word_vld = 1'b0;
        m_loaded[m_ofs] = 1'b1; m_data[m_ofs] = d;
        m_ofs = m_ofs + 2'd1;
    endtask

    task automatic run_commit(string tag, bit inject);
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        for (int s = 0; s < 4; s++) begin
            chk({tag, " R5 busy"}, 32'(busy), 32'd1);
            chk({tag, " R4 vld"}, 32'(wr_vld), 32'(m_loaded[s]));
            chk({tag, " R2 addr"}, 32'(wr_addr), 32'({m_base, 2'(s)}));
            if (m_loaded[s]) chk({tag, " R3 data"}, 32'(wr_data), 32'(m_data[s]));
            if (inject && s == 0) begin
                word_vld = 1'b1; word_data = 16'hDEAD;
                clr = 1'b1; start_addr = 8'hFF; commit_req = 1'b1;
            end
            @(negedge clk);
            word_vld = 1'b0; clr = 1'b0; commit_req = 1'b0;
        end
        chk({tag, " R5 done"}, 32'(commit_done), 32'd1);
        chk({tag, " R5 no vld at done"}, 32'(wr_vld), 32'd0);
        @(negedge clk);
        chk({tag, " R5 done width"}, 32'(commit_done), 32'd0);
        chk({tag, " R7 idle after"}, 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        chk("R8 wr_vld", 32'(wr_vld), 32'd0);
        chk("R8 done", 32'(commit_done), 32'd0);
        chk("R8 busy", 32'(busy), 32'd0);
    endtask

    task automatic t_single();
        start_instr(8'h2E);
        send_word(16'hA5A5);
        run_commit("single", 1'b0);
    endtask

    task automatic t_wrap4();
        start_instr(8'h41);
        send_word(16'h1111); send_word(16'h2222);
        send_word(16'h3333); send_word(16'h4444);
        chk("R3 slot0 holds 4th", 32'(m_data[0]), 32'h4444);
        run_commit("wrap4", 1'b0);
    endtask

    task automatic t_six();
        start_instr(8'h10);
        for (int i = 1; i <= 6; i++) send_word(16'(16'hB000 + i));
        chk("R3 model slot0", 32'(m_data[0]), 32'hB005);
        chk("R3 model slot1", 32'(m_data[1]), 32'hB006);
        run_commit("six", 1'b0);
    endtask

    task automatic t_abort();
        start_instr(8'h84);
        send_word(16'h0F0F); send_word(16'hF0F0);
        partial_abort = 1'b1;
        @(negedge clk);
        partial_abort = 1'b0;
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk("R6 no write", 32'({wr_vld, commit_done, busy}), 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_empty();
        start_instr(8'hC8);
        run_commit("empty", 1'b0);
    endtask

    task automatic t_clr_prio();
        start_instr(8'h30);
        clr = 1'b1; start_addr = 8'h5A; word_vld = 1'b1; word_data = 16'h7777;
        @(negedge clk);
        clr = 1'b0; word_vld = 1'b0;
        m_base = 6'h16; m_ofs = 2'd2;
        send_word(16'h8888);
        run_commit("R1 clr wins", 1'b0);
    endtask

    task automatic t_busy_ignore();
        start_instr(8'h67);
        send_word(16'hCAFE);
        run_commit("R7 inject", 1'b1);
        run_commit("R7 repeat", 1'b0);
    endtask

    task automatic t_flags_cleared();
        start_instr(8'h00);
        for (int i = 0; i < 4; i++) send_word(16'(16'h5500 + i));
        start_instr(8'h01);
        send_word(16'h9999);
        run_commit("R1 fresh flags", 1'b0);
    endtask

    initial begin
        #(20 * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_wrap4();
        t_six();
        t_abort();
        t_empty();
        t_clr_prio();
        t_busy_ignore();
        t_flags_cleared();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule